// File: doc/BRIEF.md
# Linked-List Transmit DMA Engine

This block is the data mover of one transmit channel. It walks a linked list of four-word data descriptors held in memory. Each descriptor names a next pointer, a buffer start address, a flags word and a buffer end address, which is the address just past the last byte. For every descriptor the engine fetches the four words through a single-word memory port. It reads the buffer a word at a time and hands the bytes, lowest address first, to a byte-stream client with a valid/ready handshake. When the buffer is exhausted it writes the descriptor back to memory and moves to the next one.

A start pulse from the register unit supplies the first descriptor address and the address of the enclosing context record. When a descriptor whose end-of-list flag is set completes, the engine reads the context record's flags word, sets its disable bit and writes it back. It then raises its end-of-list output and goes idle until the next start. Three pointer outputs report progress: the current descriptor address, the saved descriptor pointer and the saved buffer pointer. The saved buffer pointer is refreshed once per chunk of `CHUNK` bytes and at the end of each buffer. A one-cycle pulse tells the interrupt logic that a descriptor with its interrupt flag has completed.

Top module: `txdma_engine`

## Requirements
- R1: After reset the engine is idle, and `mem_req_o`, `out_valid_o`, `busy_o`, `eol_o` and `intr_set_o` are low. `cur_ptr_o`, `saved_data_o` and `saved_buf_o` are zero.
- R2: A start pulse while idle clears `eol_o` and raises `busy_o` by the next cycle. It loads `saved_data_o` with the start address. The descriptor is then read as four words at offsets +0 (next), +4 (buffer start), +8 (flags), +12 (buffer end). Once the fourth word arrives, `cur_ptr_o` equals the address that was fetched.
- R3: The bytes from buffer start up to buffer end minus one are sent in ascending address order. The byte at address A is bits 8*(A mod 4)+7 down to 8*(A mod 4) of the memory word at A with its two low bits cleared. A descriptor whose end equals its start sends no byte.
- R4: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o` and `out_last_o` hold their values.
- R5: `out_last_o` is high on the final byte of a descriptor exactly when bit 3 of its flags word is set, and low on every other byte.
- R6: `intr_set_o` pulses for one cycle after a descriptor completes if bit 4 of its flags word is set, and does not pulse otherwise.
- R7: After a descriptor completes, its four words are written back, unchanged, to offsets +0, +4, +8, +12 of its own address, in that order.
- R8: If bit 0 of the completed descriptor's flags is clear, `saved_data_o` takes its next pointer and the engine fetches that descriptor.
- R9: If bit 0 is set, the engine reads the word at context address +4 and writes it back with bit 15 set. It then raises `eol_o`, drops `busy_o` and sends nothing more.
- R10: `saved_buf_o` takes the buffer start when a descriptor is fetched. It advances to the byte pointer after every `CHUNK` bytes accepted within that descriptor, and to the buffer end when the descriptor completes.
- R11: A start pulse while the engine is busy is ignored.
- R12: Every memory request has a word-aligned address. It holds its address, write enable and write data stable until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse from the register unit |
| start_desc_i | input | AW | Address of the first data descriptor |
| ctx_addr_i | input | AW | Address of the enclosing context record |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed; read data valid |
| mem_rdata_i | input | 32 | Read data |
| out_valid_o | output | 1 | Byte available to the client |
| out_data_o | output | 8 | Byte to the client |
| out_last_o | output | 1 | Final byte of a packet-ending descriptor |
| out_ready_i | input | 1 | Client accepts the byte |
| busy_o | output | 1 | Engine is walking a list |
| eol_o | output | 1 | End of list reached |
| intr_set_o | output | 1 | Raw interrupt set pulse |
| cur_ptr_o | output | AW | Address of the last fetched descriptor |
| saved_data_o | output | AW | Saved descriptor pointer |
| saved_buf_o | output | AW | Saved buffer pointer |

## Verification
The assertions check on every cycle that the memory request and the byte stream obey their handshakes. They also check that addresses are aligned and that the interrupt line is a single-cycle pulse. Further per-cycle checks cover the start from idle, the end-of-list flag rising only after the context write completes, and the engine ignoring a start while busy. Only the bench's scenarios can show the content side of the function. This means the byte order across unaligned buffers and empty buffers, the chunked updates of the saved buffer pointer, and the last-byte marker and interrupt count per descriptor. It also means the exact sequence of descriptor and context write-backs with their data, and the final pointer values after chains of varying length.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    // Word index within a four-word data descriptor
    localparam int W_NEXT  = 0;
    localparam int W_BUF   = 1;
    localparam int W_FLAGS = 2;
    localparam int W_END   = 3;
    localparam int DESC_WORDS = 4;

    // Bit positions in the descriptor flags word
    localparam int F_EOL  = 0;
    localparam int F_OEOP = 3;
    localparam int F_INTR = 4;

    // Disable bit in the context record flags word (at offset +4)
    localparam int CTX_DIS     = 15;
    localparam int CTX_FLAG_OF = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_RDBUF,
        S_SEND,
        S_FIN,
        S_WB,
        S_CTX_RD,
        S_CTX_WR
    } txdma_state_e;

    typedef logic [31:0] txdma_word_t;

    function automatic logic [3:0] word_offset(input logic [1:0] idx);
        return {idx, 2'b00};
    endfunction

endpackage

// File: rtl/txdma_lane_sel.sv
module txdma_lane_sel
    import txdma_pkg::*;
(
    input  txdma_word_t word_i,
    input  logic [1:0]  sel_i,
    output logic [7:0]  byte_o
);
    logic [7:0] lanes [4];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign lanes[g] = word_i[8*g +: 8];
    end

    assign byte_o = lanes[sel_i];
endmodule

// File: rtl/txdma_chunk_ctr.sv
module txdma_chunk_ctr #(
    parameter int CHUNK = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic wrap_o
);
    localparam int CW = (CHUNK > 1) ? $clog2(CHUNK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CHUNK - 1);

    logic [CW-1:0] cnt_q;

    assign wrap_o = inc_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
    import txdma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CHUNK = 2048
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] start_desc_i,
    input  logic [AW-1:0] ctx_addr_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [31:0]   mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [31:0]   mem_rdata_i,
    output logic          out_valid_o,
    output logic [7:0]    out_data_o,
    output logic          out_last_o,
    input  logic          out_ready_i,
    output logic          busy_o,
    output logic          eol_o,
    output logic          intr_set_o,
    output logic [AW-1:0] cur_ptr_o,
    output logic [AW-1:0] saved_data_o,
    output logic [AW-1:0] saved_buf_o
);
    txdma_state_e  state_q;
    logic [1:0]    widx_q;
    txdma_word_t   desc_q [DESC_WORDS];
    txdma_word_t   word_q;
    txdma_word_t   ctx_word_q;
    logic [AW-1:0] desc_addr_q;
    logic [AW-1:0] ctx_addr_q;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] cur_ptr_q;
    logic [AW-1:0] saved_data_q;
    logic [AW-1:0] saved_buf_q;
    logic          eol_q;

    logic [AW-1:0] buf_start;
    logic [AW-1:0] buf_end;
    logic [AW-1:0] next_ptr;
    logic [AW-1:0] ptr_nxt;
    logic          accept;
    logic          fetch_done;
    logic          chunk_wrap;

    assign buf_start  = desc_q[W_BUF][AW-1:0];
    assign buf_end    = desc_q[W_END][AW-1:0];
    assign next_ptr   = desc_q[W_NEXT][AW-1:0];
    assign ptr_nxt    = ptr_q + 1'b1;
    assign accept     = (state_q == S_SEND) && out_ready_i;
    assign fetch_done = (state_q == S_FETCH) && mem_ack_i && (widx_q == 2'd3);

    txdma_chunk_ctr #(.CHUNK(CHUNK)) u_chunk (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (fetch_done),
        .inc_i  (accept),
        .wrap_o (chunk_wrap)
    );

    txdma_lane_sel u_lane (
        .word_i (word_q),
        .sel_i  (ptr_q[1:0]),
        .byte_o (out_data_o)
    );

    // Memory port decode
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_addr_q + AW'(word_offset(widx_q));
            end
            S_RDBUF: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {ptr_q[AW-1:2], 2'b00};
            end
            S_WB: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_addr_q + AW'(word_offset(widx_q));
                mem_wdata_o = desc_q[widx_q];
            end
            S_CTX_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ctx_addr_q + AW'(CTX_FLAG_OF);
            end
            S_CTX_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ctx_addr_q + AW'(CTX_FLAG_OF);
                mem_wdata_o = ctx_word_q;
            end
            default: ;
        endcase
    end

    assign out_valid_o  = (state_q == S_SEND);
    assign out_last_o   = (state_q == S_SEND) && (ptr_nxt == buf_end)
                          && desc_q[W_FLAGS][F_OEOP];
    assign intr_set_o   = (state_q == S_FIN) && desc_q[W_FLAGS][F_INTR];
    assign busy_o       = (state_q != S_IDLE);
    assign eol_o        = eol_q;
    assign cur_ptr_o    = cur_ptr_q;
    assign saved_data_o = saved_data_q;
    assign saved_buf_o  = saved_buf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            widx_q       <= '0;
            word_q       <= '0;
            ctx_word_q   <= '0;
            desc_addr_q  <= '0;
            ctx_addr_q   <= '0;
            ptr_q        <= '0;
            cur_ptr_q    <= '0;
            saved_data_q <= '0;
            saved_buf_q  <= '0;
            eol_q        <= 1'b0;
            for (int i = 0; i < DESC_WORDS; i++) begin
                desc_q[i] <= '0;
            end
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        eol_q        <= 1'b0;
                        desc_addr_q  <= start_desc_i;
                        saved_data_q <= start_desc_i;
                        ctx_addr_q   <= ctx_addr_i;
                        widx_q       <= '0;
                        state_q      <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (mem_ack_i) begin
                        desc_q[widx_q] <= mem_rdata_i;
                        widx_q         <= widx_q + 1'b1;
                        if (widx_q == 2'd3) begin
                            ptr_q       <= buf_start;
                            saved_buf_q <= buf_start;
                            cur_ptr_q   <= desc_addr_q;
                            state_q     <= (mem_rdata_i[AW-1:0] == buf_start)
                                           ? S_FIN : S_RDBUF;
                        end
                    end
                end
                S_RDBUF: begin
                    if (mem_ack_i) begin
                        word_q  <= mem_rdata_i;
                        state_q <= S_SEND;
                    end
                end
                S_SEND: begin
                    if (out_ready_i) begin
                        ptr_q <= ptr_nxt;
                        if (ptr_nxt == buf_end) begin
                            saved_buf_q <= ptr_nxt;
                            state_q     <= S_FIN;
                        end else begin
                            if (chunk_wrap) begin
                                saved_buf_q <= ptr_nxt;
                            end
                            if (ptr_nxt[1:0] == 2'b00) begin
                                state_q <= S_RDBUF;
                            end
                        end
                    end
                end
                S_FIN: begin
                    widx_q  <= '0;
                    state_q <= S_WB;
                end
                S_WB: begin
                    if (mem_ack_i) begin
                        widx_q <= widx_q + 1'b1;
                        if (widx_q == 2'd3) begin
                            if (desc_q[W_FLAGS][F_EOL]) begin
                                state_q <= S_CTX_RD;
                            end else begin
                                desc_addr_q  <= next_ptr;
                                saved_data_q <= next_ptr;
                                state_q      <= S_FETCH;
                            end
                        end
                    end
                end
                S_CTX_RD: begin
                    if (mem_ack_i) begin
                        ctx_word_q <= mem_rdata_i | (32'd1 << CTX_DIS);
                        state_q    <= S_CTX_WR;
                    end
                end
                S_CTX_WR: begin
                    if (mem_ack_i) begin
                        eol_q   <= 1'b1;
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txdma_engine_chk.sv
module txdma_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [31:0]   mem_wdata_o,
    input logic          mem_ack_i,
    input logic          out_valid_o,
    input logic [7:0]    out_data_o,
    input logic          out_last_o,
    input logic          out_ready_i,
    input logic          busy_o,
    input logic          eol_o,
    input logic          intr_set_o
);
    AST_MEM_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00)); // R12

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o))); // R12

    AST_OUT_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
            && $stable(out_last_o))); // R4

    AST_INTR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        intr_set_o |=> !intr_set_o); // R6

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !eol_o)); // R2

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o && !eol_o) |=> !eol_o || !busy_o); // R11

    AST_EOL_AFTER_CTX_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(eol_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i)); // R9

    AST_EOL_QUIET: assert property (@(posedge clk) disable iff (rst)
        eol_o |-> (!out_valid_o && !busy_o)); // R9
endmodule

bind txdma_engine txdma_engine_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o),
    .out_ready_i (out_ready_i),
    .busy_o      (busy_o),
    .eol_o       (eol_o),
    .intr_set_o  (intr_set_o)
);

// File: tb/txdma_engine_bench.sv
`timescale 1ns/1ps
module txdma_engine_bench;
    localparam int AW = 32;
    localparam int CH = 8;
    localparam int CTX = 32'h20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_desc_i = '0;
    logic [AW-1:0] ctx_addr_i = CTX;
    logic          mem_req_o, mem_we_o, mem_ack_i;
    logic [AW-1:0] mem_addr_o;
    logic [31:0]   mem_wdata_o, mem_rdata_i;
    logic          out_valid_o, out_last_o, out_ready_i;
    logic [7:0]    out_data_o;
    logic          busy_o, eol_o, intr_set_o;
    logic [AW-1:0] cur_ptr_o, saved_data_o, saved_buf_o;

    always #4 clk = ~clk;

    txdma_engine #(.AW(AW), .CHUNK(CH)) u_txdma_engine (.*);

    // Memory model: reads only; writes go to a log
    logic [31:0] mem [1024];
    logic [31:0] wlog_a [1024];
    logic [31:0] wlog_d [1024];
    int          wlog_n;
    int          dly;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack_i   <= 1'b0;
            mem_rdata_i <= '0;
            dly         <= 0;
            wlog_n      <= 0;
        end else begin
            mem_ack_i <= 1'b0;
            if (mem_req_o && !mem_ack_i) begin
                if (dly != 0) begin
                    dly <= dly - 1;
                end else begin
                    mem_ack_i   <= 1'b1;
                    mem_rdata_i <= mem[mem_addr_o[11:2]];
                    if (mem_we_o) begin
                        wlog_a[wlog_n] <= mem_addr_o;
                        wlog_d[wlog_n] <= mem_wdata_o;
                        wlog_n         <= wlog_n + 1;
                    end
                    dly <= int'($urandom_range(0, 2));
                end
            end
        end
    end

    // Client ready, changed away from the edges
    int ready_pct = 75;
    initial begin
        out_ready_i = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            out_ready_i = (int'($urandom_range(0, 99)) < ready_pct);
        end
    end

    // Expected stream, cumulative over all runs
    logic [7:0]  exp_byte [4096];
    logic        exp_last [4096];
    logic [31:0] exp_bstart [4096];
    int          exp_k [4096];
    int          exp_n = 0;
    int          exp_intr = 0;
    logic [31:0] exp_wa [1024];
    logic [31:0] exp_wd [1024];
    int          exp_wn = 0;

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errors = 0;
    int pos = 0, intr_seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (intr_set_o) intr_seen <= intr_seen + 1;
            if (out_valid_o && out_ready_i) begin
                mon_checks <= mon_checks + 1;
                if (pos >= exp_n) begin
                    mon_errors <= mon_errors + 1;
                    $display("FAIL R3 extra byte %02h expected none", out_data_o);
                end else begin
                    if (out_data_o !== exp_byte[pos]) begin
                        mon_errors <= mon_errors + 1;
                        $display("FAIL R3/R4 byte %0d got %02h exp %02h", pos, out_data_o, exp_byte[pos]);
                    end
                    if (out_last_o !== exp_last[pos]) begin
                        mon_errors <= mon_errors + 1;
                        $display("FAIL R5 last %0d got %0b exp %0b", pos, out_last_o, exp_last[pos]);
                    end
                    if (saved_buf_o !== exp_bstart[pos] + 32'(CH * (exp_k[pos] / CH))) begin
                        mon_errors <= mon_errors + 1;
                        $display("FAIL R10 saved_buf at %0d got %h exp %h", pos, saved_buf_o,
                                 exp_bstart[pos] + 32'(CH * (exp_k[pos] / CH)));
                    end
                end
                pos <= pos + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        logic [31:0] w = mem[a[11:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    // Per-run descriptor plan
    int          n_desc;
    int          len_a [4];
    int          off_a [4];
    logic [31:0] fl_a  [4];

    task automatic run_list(input bit poke);
        logic [31:0] da, bs, be, fl, ctxw, last_da, last_be;
        int          wbase;
        for (int w = 256; w < 1024; w++) mem[w] = $urandom;
        mem[CTX/4]     = $urandom;
        ctxw           = $urandom & ~32'h8000;
        mem[CTX/4 + 1] = ctxw;
        last_da = '0;
        last_be = '0;
        for (int i = 0; i < n_desc; i++) begin
            da = 32'h100 + 32'(16 * i);
            bs = 32'h400 + 32'(64 * i + off_a[i]);
            be = bs + 32'(len_a[i]);
            fl = (fl_a[i] & ~32'h1) | ((i == n_desc - 1) ? 32'h1 : 32'h0);
            mem[da[11:2]]     = (i == n_desc - 1) ? $urandom : da + 32'h10;
            mem[da[11:2] + 1] = bs;
            mem[da[11:2] + 2] = fl;
            mem[da[11:2] + 3] = be;
            for (int b = 0; b < len_a[i]; b++) begin
                exp_byte[exp_n]   = byte_at(bs + 32'(b));
                exp_last[exp_n]   = (b == len_a[i] - 1) && fl[3];
                exp_bstart[exp_n] = bs;
                exp_k[exp_n]      = b;
                exp_n++;
            end
            if (fl[4]) exp_intr++;
            for (int w = 0; w < 4; w++) begin
                exp_wa[exp_wn] = da + 32'(4 * w);
                exp_wd[exp_wn] = mem[da[11:2] + 2'(w)];
                exp_wn++;
            end
            last_da = da;
            last_be = be;
        end
        exp_wa[exp_wn] = CTX + 4;
        exp_wd[exp_wn] = ctxw | 32'h8000;
        exp_wn++;
        wbase = wlog_n;

        @(negedge clk);
        start_desc_i = 32'h100;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!eol_o && busy_o, "R2 start clears eol and goes busy", {30'd0, eol_o, busy_o}, 32'h1);
        check(saved_data_o == 32'h100, "R2 saved_data at start", saved_data_o, 32'h100);
        if (poke) begin
            repeat (12) @(negedge clk);
            start_desc_i = 32'h3F0;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            start_desc_i = 32'h100;
        end
        for (int c = 0; c < 20000 && !(eol_o && !busy_o); c++) @(negedge clk);
        @(negedge clk);
        check(eol_o && !busy_o, "R9 eol raised and idle", {30'd0, eol_o, busy_o}, 32'h2);
        check(pos == exp_n, "R3 byte count (R11 poke ignored)", pos, exp_n);
        check(intr_seen == exp_intr, "R6 interrupt pulses", intr_seen, exp_intr);
        check(wlog_n - wbase == n_desc * 4 + 1, "R7 write count", wlog_n - wbase, n_desc * 4 + 1);
        for (int w = 0; w < n_desc * 4 + 1; w++) begin
            int e = exp_wn - (n_desc * 4 + 1) + w;
            check(wlog_a[wbase + w] == exp_wa[e], (w == n_desc * 4) ? "R9 ctx write addr" : "R7 wb addr",
                  wlog_a[wbase + w], exp_wa[e]);
            check(wlog_d[wbase + w] == exp_wd[e], (w == n_desc * 4) ? "R9 ctx disable bit" : "R7 wb data",
                  wlog_d[wbase + w], exp_wd[e]);
        end
        check(cur_ptr_o == last_da, "R2 cur_ptr is last fetched", cur_ptr_o, last_da);
        check(saved_data_o == last_da, "R8 saved_data follows next", saved_data_o, last_da);
        check(saved_buf_o == last_be, "R10 saved_buf at end", saved_buf_o, last_be);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240607);
        for (int w = 0; w < 1024; w++) mem[w] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!mem_req_o && !out_valid_o && !busy_o && !eol_o && !intr_set_o, "R1 reset idle",
              {27'd0, mem_req_o, out_valid_o, busy_o, eol_o, intr_set_o}, 32'h0);
        check(cur_ptr_o == 0 && saved_data_o == 0 && saved_buf_o == 0, "R1 reset pointers",
              cur_ptr_o | saved_data_o | saved_buf_o, 32'h0);

        // Directed: one unaligned descriptor with marker and interrupt
        n_desc = 1; len_a[0] = 13; off_a[0] = 3; fl_a[0] = 32'hABCD0018;
        run_list(1'b0);

        // Directed: empty buffer, exact chunk, odd length with stalls
        ready_pct = 40;
        n_desc = 3;
        len_a[0] = 0;  off_a[0] = 1; fl_a[0] = 32'h00000018;
        len_a[1] = 8;  off_a[1] = 0; fl_a[1] = 32'h12340020;
        len_a[2] = 17; off_a[2] = 2; fl_a[2] = 32'h00000818;
        run_list(1'b0);

        // Directed: start pulse while busy must be ignored
        ready_pct = 75;
        n_desc = 2;
        len_a[0] = 20; off_a[0] = 1; fl_a[0] = 32'h10;
        len_a[1] = 9;  off_a[1] = 3; fl_a[1] = 32'h08;
        run_list(1'b1);

        // Random chains
        for (int r = 0; r < 10; r++) begin
            ready_pct = int'($urandom_range(20, 100));
            n_desc = int'($urandom_range(1, 4));
            for (int i = 0; i < n_desc; i++) begin
                len_a[i] = int'($urandom_range(0, 30));
                off_a[i] = int'($urandom_range(0, 3));
                fl_a[i]  = $urandom;
            end
            run_list(r[0]);
        end

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
        $finish;
    end

    initial begin
        #(8 * 190000);
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errors + 1);
        $finish;
    end
endmodule